// File: doc/BRIEF.md
# Fused Micro-Op Execution Unit

This unit evaluates one fused two-instruction operation per cycle on 64-bit operands. An issue stage gives it a class code, a 6-bit parameter and two source operands. One clock later it returns the value that the original instruction pair would have left in its destination register, together with a valid flag. Each class stands for one short idiom: extension, shift-and-add, byte extraction, conditional increment, word add with a narrowing step, a logic operation with a narrowing step, a byte-merging OR, and a narrow multiply.

The output side is a two-state machine. OUT_IDLE means no result is presented and OUT_LOADED means a result is presented. A valid input moves the machine to OUT_LOADED, from either state. A cycle with no valid input moves it to OUT_IDLE. Reset forces OUT_IDLE. The result register loads only on a valid input, so it keeps its value while the machine is idle.

Class codes (in_cls): 0 zero-extend halfword, 1 sign-extend halfword, 2 shift-left-add, 3 zero-extended-word shift, 4 second byte, 5 shift-right-add, 6 add-one-if-odd, 7 word-add-extract, 8 logic-extract, 9 or-merge, 10 narrow multiply. Codes 11 to 15 are unused.

Top module: `fuse_exec`

## Requirements
- R1: A cycle with in_valid high and rst low makes out_valid high on the next cycle, and out_result then shows that input's result. This holds for back-to-back inputs.
- R2: A cycle with in_valid low makes out_valid low on the next cycle, and out_result keeps its previous value whatever the other inputs are.
- R3: Class 0 returns src1[15:0] with zeros above it. Class 1 returns src1[15:0] with bit 15 copied into bits 63:16.
- R4: Class 2 returns (src1 << in_param) + src2 modulo 2^64, for shift amounts 1 to 4.
- R5: Class 3 zero-extends src1[31:0] to 64 bits and shifts the result left by in_param (1, 2 or 3).
- R6: Class 4 returns src1[15:8] in bits 7:0, and all higher bits are zero.
- R7: Class 5 returns (src1 logically shifted right by in_param) + src2 modulo 2^64, for shift amounts 29 to 32.
- R8: Class 6 with in_param[0]=0 returns src2 + src1[0]. With in_param[0]=1 it returns the 32-bit sum src2[31:0] + src1[0], sign-extended from bit 31.
- R9: Class 7 forms w = src1[31:0] + src2[31:0] (32 bits). in_param[1:0] then selects the result: 0 gives w AND 1, 1 gives w AND 255, 2 gives w[15:0] zero-extended, 3 gives w[15:0] sign-extended.
- R10: Class 8 applies an operation selected by in_param[1:0]: 0 AND, 1 OR, 2 XOR, 3 byte-wise OR-combine of src1 (each byte becomes 0xFF if it is nonzero, else 0x00). in_param[2]=0 keeps only bit 0 of that value, and in_param[2]=1 keeps bits 15:0, both zero-extended.
- R11: Class 9 returns src1 with bits 7:0 cleared, ORed with src2.
- R12: Class 10 multiplies src1[6:0] by src2 and returns the low 32 bits of the product, sign-extended from bit 31.
- R13: Class codes 11 to 15 give a zero result, and out_valid is still asserted.
- R14: Reset is synchronous and active high. It clears out_valid and out_result, and it overrides an in_valid that is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| in_cls | input | 4 | Fused class code |
| in_param | input | 6 | Shift amount or sub-mode selector |
| in_src1 | input | 64 | First source operand |
| in_src2 | input | 64 | Second source operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 64 | Registered result |

## Verification
Two events can fall in the same cycle: the state machine's load transition on in_valid and its reset transition. The bench raises rst in a cycle where in_valid is high and carries a nonzero operation. It then checks that out_valid is low and out_result is zero, so the reset transition wins. With in_valid still held high, it releases rst and checks that the next cycle loads the pending operation. The pairing of an idle cycle with changing operands is also judged: out_result must not move while the machine is in OUT_IDLE.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int unsigned CLS_W   = 4;
    localparam int unsigned PARAM_W = 6;

    typedef enum logic [CLS_W-1:0] {
        FC_LO16  = 4'd0,
        FC_SX16  = 4'd1,
        FC_SHADD = 4'd2,
        FC_ZWSHL = 4'd3,
        FC_BYTE1 = 4'd4,
        FC_SRADD = 4'd5,
        FC_ODD   = 4'd6,
        FC_WEXT  = 4'd7,
        FC_LOGX  = 4'd8,
        FC_ORCAT = 4'd9,
        FC_MUL7  = 4'd10
    } fuse_cls_e;

    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_LOADED = 1'b1
    } out_state_e;

endpackage

// File: rtl/fuse_arith.sv
// Adder-based classes: shift-left-add, shift-right-add, add-one-if-odd, or-merge.
module fuse_arith
    import fuse_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  fuse_cls_e            cls,
    input  logic [PARAM_W-1:0]   param,
    input  logic [DATA_W-1:0]    src1,
    input  logic [DATA_W-1:0]    src2,
    output logic [DATA_W-1:0]    res
);
    localparam int unsigned WORD_W = DATA_W / 2;
    localparam int unsigned BYTE_W = 8;

    logic [WORD_W-1:0] word_sum;
    logic [DATA_W-1:0] odd_inc;

    always_comb begin
        odd_inc  = {{(DATA_W-1){1'b0}}, src1[0]};
        word_sum = src2[WORD_W-1:0] + odd_inc[WORD_W-1:0];
        case (cls)
            FC_SHADD: res = (src1 << param) + src2;
            FC_SRADD: res = (src1 >> param) + src2;
            FC_ODD:   res = param[0] ? {{WORD_W{word_sum[WORD_W-1]}}, word_sum}
                                     : src2 + odd_inc;
            FC_ORCAT: res = {src1[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}} | src2;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/fuse_extract.sv
// Narrowing classes: halfword extension, word shift, byte pick, word-add-extract, logic-extract.
module fuse_extract
    import fuse_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  fuse_cls_e                  cls,
    input  logic [PARAM_W-1:0]         param,
    input  logic [DATA_W/2-1:0]        src1_lo,
    input  logic [DATA_W/2-1:0]        src2_lo,
    output logic [DATA_W-1:0]          res
);
    localparam int unsigned WORD_W = DATA_W / 2;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NBYTES = HALF_W / BYTE_W;

    logic [WORD_W-1:0] wsum;
    logic [HALF_W-1:0] orc_lo;
    logic [HALF_W-1:0] lop;

    // Only the low halfword of the byte OR-combine can survive the extract step.
    for (genvar b = 0; b < NBYTES; b++) begin : g_orc
        assign orc_lo[b*BYTE_W +: BYTE_W] = {BYTE_W{|src1_lo[b*BYTE_W +: BYTE_W]}};
    end

    assign wsum = src1_lo + src2_lo;

    always_comb begin
        case (param[1:0])
            2'd0:    lop = src1_lo[HALF_W-1:0] & src2_lo[HALF_W-1:0];
            2'd1:    lop = src1_lo[HALF_W-1:0] | src2_lo[HALF_W-1:0];
            2'd2:    lop = src1_lo[HALF_W-1:0] ^ src2_lo[HALF_W-1:0];
            default: lop = orc_lo;
        endcase
    end

    always_comb begin
        case (cls)
            FC_LO16:  res = {{(DATA_W-HALF_W){1'b0}}, src1_lo[HALF_W-1:0]};
            FC_SX16:  res = {{(DATA_W-HALF_W){src1_lo[HALF_W-1]}}, src1_lo[HALF_W-1:0]};
            FC_ZWSHL: res = {{WORD_W{1'b0}}, src1_lo} << param;
            FC_BYTE1: res = {{(DATA_W-BYTE_W){1'b0}}, src1_lo[HALF_W-1:BYTE_W]};
            FC_WEXT: begin
                case (param[1:0])
                    2'd0:    res = {{(DATA_W-1){1'b0}}, wsum[0]};
                    2'd1:    res = {{(DATA_W-BYTE_W){1'b0}}, wsum[BYTE_W-1:0]};
                    2'd2:    res = {{(DATA_W-HALF_W){1'b0}}, wsum[HALF_W-1:0]};
                    default: res = {{(DATA_W-HALF_W){wsum[HALF_W-1]}}, wsum[HALF_W-1:0]};
                endcase
            end
            FC_LOGX:  res = param[2] ? {{(DATA_W-HALF_W){1'b0}}, lop}
                                     : {{(DATA_W-1){1'b0}}, lop[0]};
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/fuse_mul7.sv
// Narrow multiply: 7-bit by word, low word of product sign-extended.
module fuse_mul7 #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NARROW_W = 7
) (
    input  logic [NARROW_W-1:0]   a_narrow,
    input  logic [DATA_W/2-1:0]   b_word,
    output logic [DATA_W-1:0]     res
);
    localparam int unsigned WORD_W = DATA_W / 2;
    localparam int unsigned PROD_W = WORD_W + NARROW_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = {{WORD_W{1'b0}}, a_narrow} * {{NARROW_W{1'b0}}, b_word};
        res  = {{WORD_W{prod[WORD_W-1]}}, prod[WORD_W-1:0]};
    end

endmodule

// File: rtl/fuse_exec.sv
module fuse_exec
    import fuse_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [3:0]           in_cls,
    input  logic [5:0]           in_param,
    input  logic [DATA_W-1:0]    in_src1,
    input  logic [DATA_W-1:0]    in_src2,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result
);
    localparam int unsigned WORD_W = DATA_W / 2;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTE_W = 8;

    fuse_cls_e   cls;
    out_state_e  state_q, state_d;
    logic [DATA_W-1:0] arith_res, ext_res, mul_res, next_res;

    assign cls = fuse_cls_e'(in_cls);

    fuse_arith #(.DATA_W(DATA_W)) u_arith (
        .cls   (cls),
        .param (in_param),
        .src1  (in_src1),
        .src2  (in_src2),
        .res   (arith_res)
    );

    fuse_extract #(.DATA_W(DATA_W)) u_extract (
        .cls     (cls),
        .param   (in_param),
        .src1_lo (in_src1[WORD_W-1:0]),
        .src2_lo (in_src2[WORD_W-1:0]),
        .res     (ext_res)
    );

    fuse_mul7 #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mul (
        .a_narrow (in_src1[NARROW_W-1:0]),
        .b_word   (in_src2[WORD_W-1:0]),
        .res      (mul_res)
    );

    always_comb begin
        unique case (cls)
            FC_SHADD, FC_SRADD, FC_ODD, FC_ORCAT:                  next_res = arith_res;
            FC_LO16, FC_SX16, FC_ZWSHL, FC_BYTE1, FC_WEXT, FC_LOGX: next_res = ext_res;
            FC_MUL7:                                               next_res = mul_res;
            default:                                               next_res = '0;
        endcase
    end

    // Next-state logic for the output state machine.
    always_comb begin
        unique case (state_q)
            OUT_IDLE:   state_d = in_valid ? OUT_LOADED : OUT_IDLE;
            OUT_LOADED: state_d = in_valid ? OUT_LOADED : OUT_IDLE;
            default:    state_d = OUT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    // Output register: loads only on a valid input.
    always_ff @(posedge clk) begin
        if (rst)           out_result <= '0;
        else if (in_valid) out_result <= next_res;
    end

    assign out_valid = (state_q == OUT_LOADED);

    // R1: valid input yields valid output next cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: idle input cycle drops valid and freezes the result
    a_r2_idle_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R3: sign-extended halfword has uniform upper bits
    a_r3_sx16_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == 4'd1) |=>
        (out_result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){out_result[HALF_W-1]}}));

    // R6: second byte leaves only bits 7:0
    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == 4'd4) |=> (out_result[DATA_W-1:BYTE_W] == '0));

    // R12: narrow multiply result is a sign-extended word
    a_r12_mul_sext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == 4'd10) |=>
        (out_result[DATA_W-1:WORD_W] == {WORD_W{out_result[WORD_W-1]}}));

    // R13: unused codes give zero with valid
    a_r13_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls > 4'd10) |=> (out_valid && out_result == '0));

    // R14: reset clears the output
    a_r14_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/fuse_exec_test.sv
module fuse_exec_test;

    localparam int N = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_cls;
    logic [5:0]  in_param;
    logic [63:0] in_src1, in_src2;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fuse_exec uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_cls     (in_cls),
        .in_param   (in_param),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    localparam logic [3:0] T_CLS [N] = '{
        4'd0, 4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd4, 4'd5, 4'd5, 4'd6,
        4'd6, 4'd6, 4'd7, 4'd7, 4'd7, 4'd7, 4'd8, 4'd8, 4'd8, 4'd8,
        4'd9, 4'd11, 4'd15, 4'd10, 4'd10};
    localparam logic [5:0] T_PAR [N] = '{
        6'd0, 6'd0, 6'd0, 6'd1, 6'd4, 6'd3, 6'd0, 6'd32, 6'd29, 6'd0,
        6'd1, 6'd1, 6'd0, 6'd1, 6'd3, 6'd2, 6'd0, 6'd6, 6'd7, 6'd3,
        6'd0, 6'd0, 6'd0, 6'd0, 6'd0};
    localparam logic [63:0] T_S1 [N] = '{
        64'hFFFF_FFFF_FFFF_8765, 64'h0000_0000_0000_8765, 64'hFFFF_FFFF_FFFF_1234,
        64'h5, 64'hF000_0000_0000_0001, 64'hFFFF_FFFF_8000_0001,
        64'h1122_3344_5566_7788, 64'hABCD_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h3, 64'h1, 64'h2,
        64'h1, 64'hF0, 64'h7FFF, 64'h7FFF_FFFF,
        64'h3, 64'hFFFF_0000_FFFF_00FF, 64'h0100, 64'h0100,
        64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FF81, 64'h7F};
    localparam logic [63:0] T_S2 [N] = '{
        64'h0, 64'h0, 64'h0,
        64'h3, 64'h1, 64'h0,
        64'h0, 64'h1, 64'h0,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF, 64'h1234_5678_0000_0005,
        64'h2, 64'h20, 64'h1, 64'h8001,
        64'h1, 64'h0F0F_0F0F, 64'h0, 64'h0,
        64'h0F, 64'h5, 64'h5,
        64'h1234_5678_8000_0000, 64'h3};
    localparam logic [63:0] T_EXP [N] = '{
        64'h8765, 64'hFFFF_FFFF_FFFF_8765, 64'h1234,          // R3
        64'hD, 64'h11, 64'h0000_0004_0000_0008,               // R4, R5
        64'h77, 64'h0000_0000_ABCD_0001, 64'h0000_0004_0000_0000, // R6, R7
        64'h0, 64'hFFFF_FFFF_8000_0000, 64'h5,               // R8
        64'h1, 64'h10, 64'hFFFF_FFFF_FFFF_8000, 64'h8000,     // R9
        64'h1, 64'h0FF0, 64'hFF00, 64'h0,                     // R10
        64'h1234_5678_9ABC_DE0F, 64'h0, 64'h0,                // R11, R13
        64'hFFFF_FFFF_8000_0000, 64'h17D};                    // R12
    localparam int T_REQ [N] = '{3,3,3,4,4,5,6,7,7,8,8,8,9,9,9,9,10,10,10,10,11,13,13,12,12};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] c, input logic [5:0] p,
                         input logic [63:0] a, input logic [63:0] b);
        in_valid = v; in_cls = c; in_param = p; in_src1 = a; in_src2 = b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 4'd0, 6'd0, 64'h0, 64'h0);
        repeat (2) @(negedge clk);
        // R14: reset state
        check("R14 reset valid", {63'b0, out_valid}, 64'h0);
        check("R14 reset result", out_result, 64'h0);
        rst = 1'b0;

        // Vector table, back-to-back valid inputs (R1 on every entry)
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            drive(1'b1, T_CLS[i], T_PAR[i], T_S1[i], T_S2[i]);
            @(negedge clk);
            check("R1 valid", {63'b0, out_valid}, 64'h1);
            check($sformatf("R%0d vector %0d", T_REQ[i], i), out_result, T_EXP[i]);
        end

        // R2: idle cycles with changing operands keep the last result
        drive(1'b0, 4'd1, 6'd0, 64'hFFFF, 64'h0);
        @(negedge clk);
        check("R2 idle valid", {63'b0, out_valid}, 64'h0);
        check("R2 hold result", out_result, 64'h17D);
        drive(1'b0, 4'd9, 6'd0, 64'h0, 64'hFF);
        @(negedge clk);
        check("R2 hold result again", out_result, 64'h17D);

        // R14: reset and valid input in the same cycle, reset wins
        rst = 1'b1;
        drive(1'b1, 4'd0, 6'd0, 64'h1234, 64'h0);
        @(negedge clk);
        check("R14 reset over valid", {63'b0, out_valid}, 64'h0);
        check("R14 reset over valid result", out_result, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset valid", {63'b0, out_valid}, 64'h1);
        check("R3 after reset result", out_result, 64'h1234);

        // R8: 64-bit form with odd src1 and carry across the word boundary
        drive(1'b1, 4'd6, 6'd0, 64'h1, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        check("R8 carry into upper word", out_result, 64'h0000_0001_0000_0000);
        drive(1'b0, 4'd0, 6'd0, 64'h0, 64'h0);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule